// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a set of control registers that exist once per hardware unit. Units are arranged as groups of instances, and every copy of a given register answers to the same bus address. A steering selector register, also on the bus, names one group and one instance and carries a broadcast flag. With the flag set, a write lands in every live copy at once. With it clear, the write lands only in the steered copy. A read always returns exactly one copy, the steered one, whatever the flag says.

A per-copy liveness input marks units that are fused off or power-gated. Any access steered to a dead unit, or to a group or instance number beyond the built range, is terminated. A terminated read returns zero. A terminated unicast write vanishes without any error. A small set of ordinary registers sits beside the replicated window and ignores steering altogether. Read data is registered and appears one cycle after the read strobe.

Top module: `rep_steer_bank`

## Requirements
- R1: After reset the selector reads 0x8000_0000 (broadcast set, group 0, instance 0), and every replicated copy and every ordinary register reads 0.
- R2: The selector (address 0x00) keeps the broadcast flag in bit 31, the group number in bits 11:8 and the instance number in bits 3:0. All other bits read as 0.
- R3: With the broadcast flag set, a write to a replicated address (0x10 to 0x13) updates that register in every live copy.
- R4: A broadcast write leaves copies whose liveness bit is 0 unchanged.
- R5: With the broadcast flag clear, a write updates only copy group*NUM_INST+instance, and it updates that copy only if the copy is live.
- R6: A unicast write steered to a copy whose liveness bit is 0 is dropped. The copy still holds its old value once it is live again.
- R7: A read of a replicated address returns the steered copy whether the broadcast flag is set or clear.
- R8: A read steered to a dead copy, or to a group of NUM_GROUPS or more, or to an instance of NUM_INST or more, returns 0. A unicast write with such an out-of-range steer changes no copy.
- R9: The ordinary registers (0x20 to 0x23) are read and written the same way whatever the selector holds.
- R10: Read data appears on the output at the clock edge that samples the read strobe. It then holds until the next read.
- R11: A read of an address mapped to nothing returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| copy_live | input | NUM_GROUPS*NUM_INST | Liveness per copy; bit group*NUM_INST+instance |

## Verification
The assertions take three things for granted. The liveness mask is stable in the cycle a strobe is sampled. Read and write strobes are never raised together. The read strobe is low in the cycle reset is released, so the first held value is the reset zero. The stimulus drives every input at the falling edge and raises only one strobe per access. It changes the liveness mask only between accesses, and it keeps both strobes low while reset is active and when reset is released.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
   localparam int SEL_MC_BIT   = 31;
   localparam int SEL_GRP_LSB  = 8;
   localparam int SEL_INST_LSB = 0;
   localparam int SEL_FIELD_W  = 4;
   localparam logic [31:0] SEL_MASK  = 32'h8000_0F0F;
   localparam logic [31:0] SEL_RESET = 32'h8000_0000;

   typedef struct packed {
      logic                   mc;
      logic [SEL_FIELD_W-1:0] grp;
      logic [SEL_FIELD_W-1:0] inst;
   } steer_t;

   typedef enum logic [1:0] {
      RG_NONE  = 2'd0,
      RG_SEL   = 2'd1,
      RG_REP   = 2'd2,
      RG_PLAIN = 2'd3
   } region_e;
endpackage

// File: rtl/rsb_addr_dec.sv
module rsb_addr_dec
   import rsb_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int SEL_ADDR   = 0,
   parameter int REP_BASE   = 16,
   parameter int REP_REGS   = 4,
   parameter int PLAIN_BASE = 32,
   parameter int PLAIN_REGS = 4,
   localparam int REP_IW    = (REP_REGS > 1) ? $clog2(REP_REGS) : 1,
   localparam int PLAIN_IW  = (PLAIN_REGS > 1) ? $clog2(PLAIN_REGS) : 1
) (
   input  logic [ADDR_W-1:0]   addr,
   output region_e             region,
   output logic [REP_IW-1:0]   rep_idx,
   output logic [PLAIN_IW-1:0] plain_idx
);
   int a_int;

   always_comb begin
      a_int     = int'(addr);
      region    = RG_NONE;
      rep_idx   = '0;
      plain_idx = '0;
      if (a_int == SEL_ADDR) begin
         region = RG_SEL;
      end else if (a_int >= REP_BASE && a_int < REP_BASE + REP_REGS) begin
         region  = RG_REP;
         rep_idx = REP_IW'(a_int - REP_BASE);
      end else if (a_int >= PLAIN_BASE && a_int < PLAIN_BASE + PLAIN_REGS) begin
         region    = RG_PLAIN;
         plain_idx = PLAIN_IW'(a_int - PLAIN_BASE);
      end
   end
endmodule

// File: rtl/rsb_steer.sv
module rsb_steer
   import rsb_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_GROUPS = 2,
   parameter int NUM_INST   = 4,
   localparam int NUM_COPIES = NUM_GROUPS * NUM_INST,
   localparam int CPY_W      = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_we,
   input  steer_t                sel_wval,
   input  logic [NUM_COPIES-1:0] copy_live,
   output logic                  sel_mc,
   output logic [CPY_W-1:0]      copy_idx,
   output logic                  in_range,
   output logic                  terminated,
   output logic [DATA_W-1:0]     sel_word
);
   steer_t sel_q;
   int     lin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q.mc   <= SEL_RESET[SEL_MC_BIT];
         sel_q.grp  <= SEL_RESET[SEL_GRP_LSB +: SEL_FIELD_W];
         sel_q.inst <= SEL_RESET[SEL_INST_LSB +: SEL_FIELD_W];
      end else if (sel_we) begin
         sel_q <= sel_wval;
      end
   end

   always_comb begin
      in_range = (int'(sel_q.grp) < NUM_GROUPS) && (int'(sel_q.inst) < NUM_INST);
      lin      = int'(sel_q.grp) * NUM_INST + int'(sel_q.inst);
      copy_idx = in_range ? CPY_W'(lin) : '0;
      terminated = !(in_range && copy_live[copy_idx]);
   end

   always_comb begin
      sel_word = '0;
      sel_word[SEL_MC_BIT]                  = sel_q.mc;
      sel_word[SEL_GRP_LSB +: SEL_FIELD_W]  = sel_q.grp;
      sel_word[SEL_INST_LSB +: SEL_FIELD_W] = sel_q.inst;
   end

   assign sel_mc = sel_q.mc;
endmodule

// File: rtl/rsb_copy_array.sv
module rsb_copy_array #(
   parameter int              DATA_W     = 32,
   parameter int              NUM_COPIES = 8,
   parameter int              NUM_REGS   = 4,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   localparam int CPY_W = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1,
   localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_COPIES-1:0] copy_we,
   input  logic [REG_W-1:0]      reg_idx,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [CPY_W-1:0]      rd_copy,
   output logic [DATA_W-1:0]     rd_word
);
   logic [DATA_W-1:0] cell_all [NUM_COPIES*NUM_REGS];

   for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic [DATA_W-1:0] cell_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cell_q <= RESET_VAL;
            else if (copy_we[c] && int'(reg_idx) == r)
               cell_q <= wdata;
         end
         assign cell_all[c*NUM_REGS + r] = cell_q;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NUM_COPIES*NUM_REGS; k++) begin
         if (k == int'(rd_copy) * NUM_REGS + int'(reg_idx))
            rd_word = cell_all[k];
      end
   end
endmodule

// File: rtl/rsb_plain_regs.sv
module rsb_plain_regs #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 4,
   localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word
);
   logic [DATA_W-1:0] word_all [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (we && int'(idx) == r)
            word_q <= wdata;
      end
      assign word_all[r] = word_q;
   end

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (k == int'(idx))
            rd_word = word_all[k];
      end
   end
endmodule

// File: rtl/rep_steer_bank.sv
module rep_steer_bank
   import rsb_pkg::*;
#(
   parameter int              DATA_W     = 32,
   parameter int              ADDR_W     = 8,
   parameter int              NUM_GROUPS = 2,
   parameter int              NUM_INST   = 4,
   parameter int              REP_REGS   = 4,
   parameter int              PLAIN_REGS = 4,
   parameter int              SEL_ADDR   = 0,
   parameter int              REP_BASE   = 16,
   parameter int              PLAIN_BASE = 32,
   parameter logic [DATA_W-1:0] REP_RESET = '0,
   localparam int NUM_COPIES = NUM_GROUPS * NUM_INST,
   localparam int CPY_W      = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1,
   localparam int REP_IW     = (REP_REGS > 1) ? $clog2(REP_REGS) : 1,
   localparam int PLAIN_IW   = (PLAIN_REGS > 1) ? $clog2(PLAIN_REGS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_COPIES-1:0] copy_live
);
   // elaboration-time parameter checks
   if (DATA_W < 32) begin : g_bad_dw
      $error("DATA_W must hold the selector layout (>= 32)");
   end
   if (NUM_GROUPS < 1 || NUM_GROUPS > 16 || NUM_INST < 1 || NUM_INST > 16) begin : g_bad_topo
      $error("group and instance counts must fit a 4-bit field");
   end
   if (NUM_COPIES < 2) begin : g_bad_copies
      $error("at least two copies are required");
   end
   if (REP_BASE <= SEL_ADDR || PLAIN_BASE < REP_BASE + REP_REGS) begin : g_bad_map
      $error("address windows overlap or are out of order");
   end
   if (PLAIN_BASE + PLAIN_REGS > (1 << ADDR_W)) begin : g_bad_aw
      $error("address map exceeds ADDR_W");
   end

   region_e               region;
   logic [REP_IW-1:0]     rep_idx;
   logic [PLAIN_IW-1:0]   plain_idx;
   steer_t                sel_wval;
   logic                  sel_mc;
   logic [CPY_W-1:0]      copy_idx;
   logic                  steer_hit;
   logic                  steer_term;
   logic [DATA_W-1:0]     sel_word;
   logic [NUM_COPIES-1:0] copy_we;
   logic [DATA_W-1:0]     rep_word;
   logic [DATA_W-1:0]     plain_word;
   logic [DATA_W-1:0]     rd_next;
   logic [DATA_W-1:0]     rdata_q;
   logic                  rep_wr;

   rsb_addr_dec #(
      .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .REP_BASE(REP_BASE),
      .REP_REGS(REP_REGS), .PLAIN_BASE(PLAIN_BASE), .PLAIN_REGS(PLAIN_REGS)
   ) u_dec (
      .addr(bus_addr), .region(region), .rep_idx(rep_idx), .plain_idx(plain_idx)
   );

   assign sel_wval.mc   = bus_wdata[SEL_MC_BIT];
   assign sel_wval.grp  = bus_wdata[SEL_GRP_LSB +: SEL_FIELD_W];
   assign sel_wval.inst = bus_wdata[SEL_INST_LSB +: SEL_FIELD_W];

   rsb_steer #(
      .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST)
   ) u_steer (
      .clk(clk), .rst_n(rst_n),
      .sel_we(bus_wr && region == RG_SEL),
      .sel_wval(sel_wval), .copy_live(copy_live),
      .sel_mc(sel_mc), .copy_idx(copy_idx), .in_range(steer_hit),
      .terminated(steer_term), .sel_word(sel_word)
   );

   assign rep_wr = bus_wr && region == RG_REP;

   for (genvar c = 0; c < NUM_COPIES; c++) begin : g_we
      assign copy_we[c] = rep_wr && copy_live[c] &&
                          (sel_mc || (steer_hit && int'(copy_idx) == c));
   end

   rsb_copy_array #(
      .DATA_W(DATA_W), .NUM_COPIES(NUM_COPIES), .NUM_REGS(REP_REGS),
      .RESET_VAL(REP_RESET)
   ) u_copies (
      .clk(clk), .rst_n(rst_n), .copy_we(copy_we), .reg_idx(rep_idx),
      .wdata(bus_wdata), .rd_copy(copy_idx), .rd_word(rep_word)
   );

   rsb_plain_regs #(
      .DATA_W(DATA_W), .NUM_REGS(PLAIN_REGS)
   ) u_plain (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && region == RG_PLAIN),
      .idx(plain_idx), .wdata(bus_wdata), .rd_word(plain_word)
   );

   always_comb begin
      unique case (region)
         RG_SEL:   rd_next = sel_word;
         RG_REP:   rd_next = steer_term ? '0 : rep_word;
         RG_PLAIN: rd_next = plain_word;
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (bus_rd)
         rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/rep_steer_bank_chk.sv
module rep_steer_bank_chk
   import rsb_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int NUM_COPIES = 8,
   parameter int SEL_ADDR   = 0,
   parameter int REP_BASE   = 16,
   parameter int REP_REGS   = 4,
   parameter int PLAIN_BASE = 32,
   parameter int PLAIN_REGS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_wr,
   input logic                  bus_rd,
   input logic [DATA_W-1:0]     bus_rdata,
   input logic [NUM_COPIES-1:0] copy_live,
   input logic [NUM_COPIES-1:0] copy_we,
   input logic                  steer_term,
   input logic                  sel_mc
);
   logic is_sel, is_rep, is_plain, is_none;
   logic [DATA_W-1:0] sel_mask_w;

   assign is_sel   = int'(bus_addr) == SEL_ADDR;
   assign is_rep   = int'(bus_addr) >= REP_BASE && int'(bus_addr) < REP_BASE + REP_REGS;
   assign is_plain = int'(bus_addr) >= PLAIN_BASE && int'(bus_addr) < PLAIN_BASE + PLAIN_REGS;
   assign is_none  = !is_sel && !is_rep && !is_plain;
   assign sel_mask_w = DATA_W'(SEL_MASK);

   a_r2_sel_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && is_sel |=> (bus_rdata & ~sel_mask_w) == '0);

   a_r4_live_only: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_we & ~copy_live) == '0);

   a_r5_unicast_single: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && is_rep && !sel_mc |-> $onehot0(copy_we));

   a_r6_term_write_drop: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && is_rep && !sel_mc && steer_term |-> copy_we == '0);

   a_r8_term_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && is_rep && steer_term |=> bus_rdata == '0);

   a_r9_plain_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !is_rep |-> copy_we == '0);

   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> $stable(bus_rdata));

   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && is_none |=> bus_rdata == '0);
endmodule

bind rep_steer_bank rep_steer_bank_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_COPIES(NUM_COPIES),
   .SEL_ADDR(SEL_ADDR), .REP_BASE(REP_BASE), .REP_REGS(REP_REGS),
   .PLAIN_BASE(PLAIN_BASE), .PLAIN_REGS(PLAIN_REGS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_rdata(bus_rdata), .copy_live(copy_live),
   .copy_we(copy_we), .steer_term(steer_term), .sel_mc(sel_mc)
);

// File: tb/rep_steer_bank_tb.sv
`timescale 1ns/1ps
module rep_steer_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  copy_live = 8'hFF;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rep_steer_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .copy_live(copy_live)
   );

   typedef struct packed {
      logic        is_wr;
      logic [7:0]  addr;
      logic [31:0] data;   // write data, or expected read data
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h00, 32'h8000_0000, 4'd3},
      '{1'b1, 8'h10, 32'hA5A5_0001, 4'd3},
      '{1'b1, 8'h00, 32'h0000_0103, 4'd5},
      '{1'b0, 8'h10, 32'hA5A5_0001, 4'd3},   // R3: copy 7 got broadcast
      '{1'b1, 8'h10, 32'h1111_7777, 4'd5},
      '{1'b0, 8'h10, 32'h1111_7777, 4'd5},   // R5: copy 7 updated
      '{1'b1, 8'h00, 32'h0000_0102, 4'd5},
      '{1'b0, 8'h10, 32'hA5A5_0001, 4'd5},   // R5: copy 6 untouched
      '{1'b1, 8'h00, 32'h8000_0103, 4'd7},
      '{1'b0, 8'h10, 32'h1111_7777, 4'd7},   // R7: broadcast flag set, steered copy read
      '{1'b1, 8'h00, 32'hFFFF_FFFF, 4'd2},
      '{1'b0, 8'h00, 32'h8000_0F0F, 4'd2},   // R2: reserved bits read 0
      '{1'b1, 8'h22, 32'hDEAD_BEEF, 4'd9},
      '{1'b1, 8'h00, 32'h0000_0000, 4'd9},
      '{1'b0, 8'h22, 32'hDEAD_BEEF, 4'd9},   // R9
      '{1'b0, 8'h33, 32'h0000_0000, 4'd11},  // R11
      '{1'b1, 8'h11, 32'h0000_00C3, 4'd5},
      '{1'b0, 8'h11, 32'h0000_00C3, 4'd5}
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(8'h00, v); check(v, 32'h8000_0000, "R1");
      rd(8'h10, v); check(v, 32'h0, "R1");
      rd(8'h20, v); check(v, 32'h0, "R1");

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) begin
            wr(VECS[i].addr, VECS[i].data);
         end else begin
            rd(VECS[i].addr, v);
            check(v, VECS[i].data, $sformatf("R%0d", VECS[i].req));
         end
      end

      // R4: broadcast skips dead copy 3
      copy_live = 8'hF7;
      wr(8'h00, 32'h8000_0000);
      wr(8'h12, 32'h0000_5555);
      copy_live = 8'hFF;
      wr(8'h00, 32'h0000_0003);
      rd(8'h12, v); check(v, 32'h0, "R4");
      wr(8'h00, 32'h0000_0002);
      rd(8'h12, v); check(v, 32'h0000_5555, "R3");

      // R6 and R8: dead copy 5 (group 1, instance 1)
      copy_live = 8'hDF;
      wr(8'h00, 32'h0000_0101);
      wr(8'h13, 32'h0000_0099);
      rd(8'h13, v); check(v, 32'h0, "R8");
      copy_live = 8'hFF;
      rd(8'h13, v); check(v, 32'h0, "R6");
      wr(8'h13, 32'h0000_0066);
      rd(8'h13, v); check(v, 32'h0000_0066, "R5");

      // R8: group out of range, then instance out of range
      wr(8'h00, 32'h0000_0200);
      wr(8'h13, 32'h0000_0077);
      rd(8'h13, v); check(v, 32'h0, "R8");
      wr(8'h00, 32'h0000_0000);
      rd(8'h13, v); check(v, 32'h0, "R8");
      wr(8'h00, 32'h0000_0005);
      wr(8'h13, 32'h0000_0088);
      wr(8'h00, 32'h0000_0101);
      rd(8'h13, v); check(v, 32'h0000_0066, "R8");

      // R9: ordinary register with out-of-range steer
      wr(8'h00, 32'h0000_0200);
      rd(8'h22, v); check(v, 32'hDEAD_BEEF, "R9");

      // R10: latency and hold
      wr(8'h00, 32'h0000_0000);
      rd(8'h11, v); check(v, 32'h0000_00C3, "R10");
      wr(8'h11, 32'h0000_0044);
      repeat (3) @(negedge clk);
      check(bus_rdata, 32'h0000_00C3, "R10");
      rd(8'h11, v); check(v, 32'h0000_0044, "R10");

      finish_run();
   end
endmodule